// File: doc/BRIEF.md
# Serial Chip-Link Transmit/Receive Handshake

This block moves one 35-bit word from one die to another over a single serial data line. A transfer clock is forwarded next to the line; in this project both sides run on the same clock. The transmit half takes a word through a parallel write strobe, but only while it is idle. It then raises a busy flag and serializes the word inside a fixed 44-cycle slot. The slot holds a one-cycle start marker, the data bits with the most significant bit first, an even parity bit, and a low idle gap.

The receive half waits for the start marker and then shifts in the data bits. It checks the parity bit, loads the word into its output register and raises a ready flag. The consumer pulses a read strobe to take the word, which clears the flag. A parity mismatch sets a sticky error flag, and the word is delivered anyway. If a new frame finishes while a word is still waiting unread, a sticky overrun flag is set and the waiting word is kept.

The transmit line output and the receive line input are separate ports, so a system or a testbench joins them directly.

Top module: `chipLinkXfer`

## Requirements
- R1: While reset is asserted and just after it is released, txBusy, txSer, rxReady, rxParityErr and rxOverrun are all low and rxData is zero.
- R2: A txWrite pulse seen at a clock edge while txBusy is low is accepted: txBusy is high in the following cycle.
- R3: A txWrite pulse while txBusy is high is ignored. The frame in progress keeps the originally accepted word, and no further frame starts after it.
- R4: Counting the cycle right after the accept edge as slot 0, txSer carries the following:
  - slot 0: a 1, the start marker;
  - slots 1 to 35: data bit 35-k in slot k, so the most significant bit goes first;
  - slot 36: the XOR of all 35 data bits (even parity);
  - slots 37 to 43: 0.
- R5: txBusy stays high for exactly 44 cycles after the accept edge and is low in slot 44.
- R6: rxReady rises 37 clock edges after the accept edge. At that point rxData holds the 35 bits taken from rxSer in slots 1 to 35.
- R7: An rxRead pulse while rxReady is high makes rxReady low in the next cycle and leaves rxData unchanged. An rxRead pulse while rxReady is low changes nothing.
- R8: While rxReady is high and rxRead is low, rxData does not change.
- R9: If the received parity bit differs from the XOR of the received data bits, rxParityErr goes high and stays high until reset. The received word is still delivered with rxReady.
- R10: If a frame completes while rxReady is high and rxRead is low, rxOverrun goes high and stays high until reset. The new word is discarded and rxData keeps the older word.
- R11: txSer is low whenever txBusy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock shared by both halves |
| rstN | input | 1 | Active-low synchronous reset |
| txWrite | input | 1 | Write strobe for the transmit word |
| txData | input | 35 | Word to transmit, sampled at acceptance |
| txBusy | output | 1 | High while a frame is being sent |
| txSer | output | 1 | Serial line driven by the transmit half |
| rxSer | input | 1 | Serial line sampled by the receive half |
| rxRead | input | 1 | Consumer read strobe |
| rxData | output | 35 | Last accepted received word |
| rxReady | output | 1 | A received word is waiting to be read |
| rxParityErr | output | 1 | Sticky parity mismatch flag |
| rxOverrun | output | 1 | Sticky flag for a frame lost while a word was waiting |

## Verification
The read-clear and word-hold properties assume that the consumer never pulses rxRead in the same cycle as a frame completion. The bench meets this because its monitor reads one cycle after it sees rxReady, and the next completion is at least 45 cycles later. The properties also assume that rxSer is a copy of txSer, except for deliberate single-bit flips inside the data slots. The bench drives rxSer as txSer XOR a flip signal that it raises for one slot, so the start marker and the idle gap are never disturbed.

// File: rtl/chipLinkPkg.sv
package chipLinkPkg;

  // strobes from transmit control to transmit datapath
  typedef struct packed {
    logic load;       // capture word, emit start marker
    logic sendData;   // emit next data bit
    logic sendParity; // emit parity bit
    logic sendGap;    // drive line low
  } txStrb_t;

  // strobes from receive control to receive datapath
  typedef struct packed {
    logic start;    // start marker seen, clear running parity
    logic shiftIn;  // take one data bit
    logic finish;   // parity bit present on the line
    logic accept;   // finished word may enter the output register
    logic clrReady; // consumer has taken the word
  } rxStrb_t;

  typedef enum logic {
    TX_IDLE,
    TX_SEND
  } txState_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_DATA,
    RX_PAR
  } rxState_e;

endpackage

// File: rtl/chipLinkTxCtrl.sv
module chipLinkTxCtrl
  import chipLinkPkg::*;
#(
  parameter int DATA_W    = 35,
  parameter int FRAME_LEN = 44
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    txWrite,
  output logic    txBusy,
  output txStrb_t strb
);

  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] DATA_END  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] PAR_SLOT  = CNT_W'(DATA_W + 1);

  txState_e        state;
  logic [CNT_W-1:0] slot;
  logic [CNT_W-1:0] nextSlot;

  assign nextSlot = slot + 1'b1;
  assign txBusy   = (state == TX_SEND);

  always_comb begin
    strb = '0;
    case (state)
      TX_IDLE: strb.load = txWrite;
      TX_SEND: begin
        if (slot == LAST_SLOT)        strb.sendGap    = 1'b1;
        else if (nextSlot <= DATA_END) strb.sendData   = 1'b1;
        else if (nextSlot == PAR_SLOT) strb.sendParity = 1'b1;
        else                           strb.sendGap    = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= TX_IDLE;
      slot  <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          slot <= '0;
          if (txWrite) state <= TX_SEND;
        end
        TX_SEND: begin
          if (slot == LAST_SLOT) begin
            state <= TX_IDLE;
            slot  <= '0;
          end else begin
            slot <= nextSlot;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chipLinkTxPath.sv
module chipLinkTxPath
  import chipLinkPkg::*;
#(
  parameter int DATA_W = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrb_t           strb,
  input  logic [DATA_W-1:0] txData,
  output logic              txSer
);

  logic [DATA_W-1:0] shReg;
  logic              parBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
      txSer  <= 1'b0;
    end else if (strb.load) begin
      shReg  <= txData;
      parBit <= ^txData;
      txSer  <= 1'b1;
    end else if (strb.sendData) begin
      txSer <= shReg[DATA_W-1];
      shReg <= {shReg[DATA_W-2:0], 1'b0};
    end else if (strb.sendParity) begin
      txSer <= parBit;
    end else if (strb.sendGap) begin
      txSer <= 1'b0;
    end
  end

endmodule

// File: rtl/chipLinkRxCtrl.sv
module chipLinkRxCtrl
  import chipLinkPkg::*;
#(
  parameter int DATA_W = 35
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxSer,
  input  logic    rxRead,
  input  logic    rxReady,
  output rxStrb_t strb
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  rxState_e         state;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strb          = '0;
    strb.clrReady = rxReady & rxRead;
    case (state)
      RX_IDLE: strb.start   = rxSer;
      RX_DATA: strb.shiftIn = 1'b1;
      RX_PAR: begin
        strb.finish = 1'b1;
        strb.accept = ~rxReady | rxRead;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          bitCnt <= '0;
          if (rxSer) state <= RX_DATA;
        end
        RX_DATA: begin
          if (bitCnt == LAST_BIT) state <= RX_PAR;
          bitCnt <= bitCnt + 1'b1;
        end
        RX_PAR:  state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chipLinkRxPath.sv
module chipLinkRxPath
  import chipLinkPkg::*;
#(
  parameter int DATA_W = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrb_t           strb,
  input  logic              rxSer,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              rxParityErr,
  output logic              rxOverrun
);

  logic [DATA_W-1:0] shReg;
  logic              runPar;
  logic              mismatch;

  assign mismatch = runPar ^ rxSer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      runPar <= 1'b0;
    end else if (strb.start) begin
      runPar <= 1'b0;
    end else if (strb.shiftIn) begin
      shReg  <= {shReg[DATA_W-2:0], rxSer};
      runPar <= runPar ^ rxSer;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData      <= '0;
      rxReady     <= 1'b0;
      rxParityErr <= 1'b0;
      rxOverrun   <= 1'b0;
    end else begin
      if (strb.finish && strb.accept) begin
        rxData  <= shReg;
        rxReady <= 1'b1;
        if (mismatch) rxParityErr <= 1'b1;
      end else if (strb.clrReady) begin
        rxReady <= 1'b0;
      end
      if (strb.finish && !strb.accept) rxOverrun <= 1'b1;
    end
  end

endmodule

// File: rtl/chipLinkXfer.sv
module chipLinkXfer
  import chipLinkPkg::*;
#(
  parameter int DATA_W    = 35,
  parameter int FRAME_LEN = 44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  output logic              txBusy,
  output logic              txSer,
  input  logic              rxSer,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              rxParityErr,
  output logic              rxOverrun
);

  txStrb_t txStrb;
  rxStrb_t rxStrb;

  chipLinkTxCtrl #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) i_txCtrl (
    .clk(clk), .rstN(rstN), .txWrite(txWrite), .txBusy(txBusy), .strb(txStrb)
  );

  chipLinkTxPath #(.DATA_W(DATA_W)) i_txPath (
    .clk(clk), .rstN(rstN), .strb(txStrb), .txData(txData), .txSer(txSer)
  );

  chipLinkRxCtrl #(.DATA_W(DATA_W)) i_rxCtrl (
    .clk(clk), .rstN(rstN), .rxSer(rxSer), .rxRead(rxRead),
    .rxReady(rxReady), .strb(rxStrb)
  );

  chipLinkRxPath #(.DATA_W(DATA_W)) i_rxPath (
    .clk(clk), .rstN(rstN), .strb(rxStrb), .rxSer(rxSer), .rxData(rxData),
    .rxReady(rxReady), .rxParityErr(rxParityErr), .rxOverrun(rxOverrun)
  );

endmodule

// File: rtl/chipLinkXferChk.sv
module chipLinkXferChk #(
  parameter int DATA_W    = 35,
  parameter int FRAME_LEN = 44
) (
  input logic              clk,
  input logic              rstN,
  input logic              txWrite,
  input logic              txBusy,
  input logic              txSer,
  input logic              rxRead,
  input logic [DATA_W-1:0] rxData,
  input logic              rxReady,
  input logic              rxParityErr,
  input logic              rxOverrun
);

  localparam int CW = $clog2(FRAME_LEN + 2);
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)       busyCnt <= '0;
    else if (txBusy) busyCnt <= busyCnt + 1'b1;
    else             busyCnt <= '0;
  end

  p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!txBusy && txWrite) |=> txBusy);

  p_start_marker_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> txSer);

  p_frame_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> (busyCnt == CW'(FRAME_LEN)));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && rxRead) |=> !rxReady);

  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !rxRead) |=> $stable(rxData));

  p_sticky_perr_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxParityErr |=> rxParityErr);

  p_sticky_ovr_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);

  p_line_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> !txSer);

endmodule

bind chipLinkXfer chipLinkXferChk #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) i_chk (.*);

// File: tb/test_chipLinkXfer.sv
module test_chipLinkXfer;
  localparam int DW = 35;
  localparam int FL = 44;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          txWrite = 1'b0;
  logic [DW-1:0] txData = '0;
  logic          lineFlip = 1'b0;
  logic          manualRead = 1'b0;
  logic          autoPulse = 1'b0;
  logic          txBusy, txSer, rxReady, rxParityErr, rxOverrun;
  logic [DW-1:0] rxData;
  wire           rxSer  = txSer ^ lineFlip;
  wire           rxRead = manualRead | autoPulse;

  int            errs = 0;
  int            checks = 0;
  bit            autoRead = 1'b1;
  bit            expErrAcc = 1'b0;
  logic [DW-1:0] expQ[$];
  bit            expErrQ[$];

  chipLinkXfer #(.DATA_W(DW), .FRAME_LEN(FL)) i_chipLinkXfer (
    .clk(clk), .rstN(rstN), .txWrite(txWrite), .txData(txData), .txBusy(txBusy),
    .txSer(txSer), .rxSer(rxSer), .rxRead(rxRead), .rxData(rxData),
    .rxReady(rxReady), .rxParityErr(rxParityErr), .rxOverrun(rxOverrun)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // monitor: pops the scoreboard when a word is waiting
  always @(negedge clk) begin
    if (rstN && autoRead && rxReady && !autoPulse) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 unexpected word", 64'(rxData), 0);
      end else begin
        logic [DW-1:0] e;
        bit pe;
        e  = expQ.pop_front();
        pe = expErrQ.pop_front();
        chk(rxData == e, "R6 word", 64'(rxData), 64'(e));
        chk(rxParityErr == pe, "R9 parity flag", 64'(rxParityErr), 64'(pe));
      end
      autoPulse = 1'b1;
    end else begin
      autoPulse = 1'b0;
    end
  end

  // driver: sends one frame and checks the line slot by slot
  task automatic sendWord(input logic [DW-1:0] d, input bit flip, input bit poke, input bit push);
    logic [DW-1:0] rx;
    @(negedge clk);
    while (txBusy) @(negedge clk);
    txWrite = 1'b1;
    txData  = d;
    if (push) begin
      rx = flip ? (d ^ (DW'(1) << (DW - 5))) : d;
      expErrAcc = expErrAcc | flip;
      expQ.push_back(rx);
      expErrQ.push_back(expErrAcc);
    end
    @(negedge clk);
    txWrite = 1'b0;
    txData  = ~d;
    chk(txBusy == 1'b1, "R2 accept", 64'(txBusy), 1);
    chk(txSer == 1'b1, "R4 start marker", 64'(txSer), 1);
    for (int k = 1; k < FL; k++) begin
      logic expBit;
      @(negedge clk);
      lineFlip = 1'b0;
      if (k <= DW)          expBit = d[DW-k];
      else if (k == DW + 1) expBit = ^d;
      else                  expBit = 1'b0;
      chk(txSer == expBit, poke ? "R3 frame kept" : "R4 slot bit", 64'(txSer), 64'(expBit));
      if (flip && k == 5) lineFlip = 1'b1;
      if (poke && k == 10) begin txWrite = 1'b1; txData = ~d; end
      if (poke && k == 11) txWrite = 1'b0;
      if (autoRead && push && k == 36) chk(!rxReady, "R6 not early", 64'(rxReady), 0);
      if (autoRead && push && k == 37) chk(rxReady, "R6 ready", 64'(rxReady), 1);
      if (autoRead && push && k == 38) chk(!rxReady, "R7 read clears", 64'(rxReady), 0);
      if (k == FL - 1) chk(txBusy, "R5 still busy", 64'(txBusy), 1);
    end
    @(negedge clk);
    chk(!txBusy, "R5 busy falls", 64'(txBusy), 0);
    chk(!txSer, "R11 line low", 64'(txSer), 0);
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        chk(!txBusy && !txSer, "R3 no second frame", 64'({txBusy, txSer}), 0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [DW-1:0] keepA;
    repeat (3) @(negedge clk);
    chk({txBusy, txSer, rxReady, rxParityErr, rxOverrun} == 5'b0, "R1 flags in reset",
        64'({txBusy, txSer, rxReady, rxParityErr, rxOverrun}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rxData == '0, "R1 data after reset", 64'(rxData), 0);
    chk(!txSer && !txBusy, "R11 idle line", 64'({txBusy, txSer}), 0);

    // read with nothing waiting
    manualRead = 1'b1;
    @(negedge clk);
    manualRead = 1'b0;
    @(negedge clk);
    chk(!rxReady && rxData == '0, "R7 idle read", 64'(rxData), 0);

    sendWord(35'h0, 1'b0, 1'b0, 1'b1);
    sendWord(35'h7_FFFF_FFFF, 1'b0, 1'b0, 1'b1);
    sendWord(35'h5_5555_5555, 1'b0, 1'b0, 1'b1);
    sendWord(35'h4_0000_0001, 1'b0, 1'b1, 1'b1);
    chk(!rxParityErr && !rxOverrun, "R9 no false flags", 64'({rxParityErr, rxOverrun}), 0);
    sendWord(35'h1_2345_6789, 1'b1, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(rxParityErr, "R9 error set", 64'(rxParityErr), 1);
    chk(!rxOverrun, "R10 no false overrun", 64'(rxOverrun), 0);

    // overrun: two frames with no read in between
    autoRead = 1'b0;
    keepA = 35'h0_ABCD_EF01;
    sendWord(keepA, 1'b0, 1'b0, 1'b1);
    sendWord(35'h7_0F0F_0F0F, 1'b0, 1'b0, 1'b0);
    chk(rxOverrun, "R10 overrun set", 64'(rxOverrun), 1);
    chk(rxReady, "R10 ready kept", 64'(rxReady), 1);
    chk(rxData == keepA, "R8 older word held", 64'(rxData), 64'(keepA));
    chk(rxParityErr, "R9 sticky", 64'(rxParityErr), 1);
    autoRead = 1'b1;
    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R10 queue drained", 64'(expQ.size()), 0);

    sendWord(35'h2_468A_CE13, 1'b0, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(rxOverrun, "R10 sticky", 64'(rxOverrun), 1);
    chk(expQ.size() == 0, "R6 all words delivered", 64'(expQ.size()), 0);
    finishRun();
  end

endmodule